// File: doc/BRIEF.md
# DES Bidirectional Round-Key Generator

This block produces the sixteen 48-bit round subkeys of one DES pass from a 64-bit key. A key is captured into a holding latch by a load strobe at any time, including while a schedule is still running. A start strobe then moves the held key into a working register and begins a new sixteen-round schedule. Each round the 56-bit working key, held as two 28-bit halves, is rotated and then compressed to a 48-bit subkey that is presented on a registered output.

The direction is chosen at each start. Forward order serves an encrypting pass and reverse order serves a decrypting pass. A Triple-DES sequencer can therefore alternate forward, reverse and forward passes with a different key each time. A start issued in the final round of one schedule begins the next schedule in the very next cycle, so no round slot is left idle between passes.

Top module: `des_subkey_gen`

## Requirements
- R1: While reset is high, and in the first cycle after it, `subKeyValid` is 0, `roundIdx` is 0, `lastRound` is 0 and `subKey` is 0.
- R2: In the cycle after a clock edge that samples `start` high, `subKeyValid` is 1 and `roundIdx` is 1.
- R3: While valid and below round 16, `roundIdx` rises by one each cycle. In the cycle after round 16, `subKeyValid` is 0 unless `start` was high. `lastRound` is 1 exactly when `subKeyValid` is 1 and `roundIdx` is 16.
- R4: With `decrypt` low at start, round r carries the standard DES forward subkey Kr. This uses permuted choice 1, left rotations of 1 in rounds 1, 2, 9 and 16 and of 2 in all other rounds, and permuted choice 2. Key bit 1 is `keyIn[63]` and subkey bit 1 is `subKey[47]`. For key 133457799BBCDFF1, K1 = 1B02EFFC7072, K2 = 79AED9DBC9E5, K3 = 55FC8A42CF99 and K16 = CB3D8B0E17F5.
- R5: With `decrypt` high at start, round r carries forward subkey K(17-r). This uses no rotation in round 1, right rotations of 1 in rounds 2, 9 and 16, and right rotations of 2 in all other rounds.
- R6: `decrypt` is sampled only at start. Changing it during a schedule has no effect on that schedule's subkeys.
- R7: `loadKey` replaces the held key without disturbing the schedule in progress. The next start uses the new key. A start in the same cycle as a load uses the previously held key.
- R8: A start sampled in round 16 begins the new schedule at round 1 in the next cycle, with no invalid cycle and with the new direction.
- R9: Key bits 8, 16, …, 64 (`keyIn[0]`, `keyIn[8]`, …, `keyIn[56]`) have no effect on any subkey.
- R10: A start sampled in the middle of a schedule abandons it and restarts at round 1.
- R11: While idle, `subKey` and `roundIdx` hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| keyIn | input | 64 | Key word; bit 1 of the key is bit 63 |
| loadKey | input | 1 | Capture keyIn into the holding latch |
| start | input | 1 | Begin a schedule from the held key |
| decrypt | input | 1 | Direction sampled at start: 1 = reverse order |
| subKey | output | 48 | Registered round subkey |
| subKeyValid | output | 1 | subKey belongs to a running schedule |
| roundIdx | output | 5 | Round number of subKey, 1 to 16 |
| lastRound | output | 1 | High in round 16 of a schedule |

## Verification
The DES geometry is fixed, so the bench builds the block with its only configuration: 28-bit halves, 16 rounds and the standard rotation pattern. That setting brings a published key schedule within reach as absolute expected values. Because reverse order mirrors forward order, it also allows a full cross-check of all sixteen rounds between the two directions. Directed runs reach the boundaries where start lands in round 16, in mid-schedule, or in the same cycle as a key load, and they also cover changes to the parity bits and to the direction input while a schedule runs.

// File: rtl/desKeyPkg.sv
package desKeyPkg;
  localparam int KEY_W   = 64;
  localparam int CD_W    = 56;
  localparam int HALF_W  = CD_W / 2;
  localparam int SUB_W   = 48;
  localparam int ROUNDS  = 16;
  localparam int RIDX_W  = $clog2(ROUNDS + 1);

  localparam int PC1_TAB [CD_W] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4};

  localparam int PC2_TAB [SUB_W] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32};

  typedef struct packed {
    logic       takeKey;   // source the round from the held key
    logic       step;      // update working halves and subkey
    logic       rotRight;  // reverse-order rotation
    logic [1:0] rotAmt;    // 0, 1 or 2 positions
  } ctlStrobe_t;

  function automatic logic [CD_W-1:0] choice1(input logic [KEY_W-1:0] k);
    logic [CD_W-1:0] o;
    for (int i = 0; i < CD_W; i++) o[CD_W-1-i] = k[KEY_W-PC1_TAB[i]];
    return o;
  endfunction

  function automatic logic [SUB_W-1:0] choice2(input logic [CD_W-1:0] cd);
    logic [SUB_W-1:0] o;
    for (int i = 0; i < SUB_W; i++) o[SUB_W-1-i] = cd[CD_W-PC2_TAB[i]];
    return o;
  endfunction
endpackage

// File: rtl/desKeyCtl.sv
module desKeyCtl
  import desKeyPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              decrypt,
  output ctlStrobe_t        ctl,
  output logic [RIDX_W-1:0] roundIdx,
  output logic              valid
);
  logic              modeRev;
  logic [RIDX_W-1:0] nextRound;
  logic              dirNext;
  logic              running;

  assign running = valid && (roundIdx < RIDX_W'(ROUNDS));

  function automatic logic [1:0] stepSize(input logic rev, input logic [RIDX_W-1:0] r);
    logic single;
    single = (r == RIDX_W'(1)) || (r == RIDX_W'(2)) ||
             (r == RIDX_W'(9)) || (r == RIDX_W'(ROUNDS));
    if (rev && r == RIDX_W'(1)) return 2'd0;
    return single ? 2'd1 : 2'd2;
  endfunction

  always_comb begin
    nextRound    = start ? RIDX_W'(1) : roundIdx + RIDX_W'(1);
    dirNext      = start ? decrypt : modeRev;
    ctl.takeKey  = start;
    ctl.step     = start || running;
    ctl.rotRight = dirNext;
    ctl.rotAmt   = stepSize(dirNext, nextRound);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      roundIdx <= '0;
      valid    <= 1'b0;
      modeRev  <= 1'b0;
    end else if (start) begin
      roundIdx <= RIDX_W'(1);
      valid    <= 1'b1;
      modeRev  <= decrypt;
    end else if (running) begin
      roundIdx <= nextRound;
    end else begin
      valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/desKeyPath.sv
module desKeyPath
  import desKeyPkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [KEY_W-1:0] keyIn,
  input  logic             loadKey,
  input  ctlStrobe_t       ctl,
  output logic [SUB_W-1:0] subKey
);
  logic [KEY_W-1:0] keyHeld;
  logic [CD_W-1:0]  work;
  logic [CD_W-1:0]  srcCd;
  logic [CD_W-1:0]  rotCd;

  function automatic logic [HALF_W-1:0] rotHalf(input logic [HALF_W-1:0] h,
                                                input logic right,
                                                input logic [1:0] amt);
    logic [HALF_W-1:0] l1, l2, r1, r2;
    l1 = {h[HALF_W-2:0], h[HALF_W-1]};
    l2 = {h[HALF_W-3:0], h[HALF_W-1:HALF_W-2]};
    r1 = {h[0], h[HALF_W-1:1]};
    r2 = {h[1:0], h[HALF_W-1:2]};
    case (amt)
      2'd1:    return right ? r1 : l1;
      2'd2:    return right ? r2 : l2;
      default: return h;
    endcase
  endfunction

  // source mux: freshly held key or the running halves
  assign srcCd = ctl.takeKey ? choice1(keyHeld) : work;

  generate
    for (genvar g = 0; g < 2; g++) begin : gHalf
      assign rotCd[g*HALF_W +: HALF_W] =
        rotHalf(srcCd[g*HALF_W +: HALF_W], ctl.rotRight, ctl.rotAmt);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) keyHeld <= '0;
    else if (loadKey) keyHeld <= keyIn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      work   <= '0;
      subKey <= '0;
    end else if (ctl.step) begin
      work   <= rotCd;
      subKey <= choice2(rotCd);
    end
  end
endmodule

// File: rtl/des_subkey_gen.sv
module des_subkey_gen
  import desKeyPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [KEY_W-1:0]  keyIn,
  input  logic              loadKey,
  input  logic              start,
  input  logic              decrypt,
  output logic [SUB_W-1:0]  subKey,
  output logic              subKeyValid,
  output logic [RIDX_W-1:0] roundIdx,
  output logic              lastRound
);
  ctlStrobe_t ctl;

  desKeyCtl uCtl (
    .clk(clk), .rst(rst), .start(start), .decrypt(decrypt),
    .ctl(ctl), .roundIdx(roundIdx), .valid(subKeyValid)
  );

  desKeyPath uPath (
    .clk(clk), .rst(rst), .keyIn(keyIn), .loadKey(loadKey),
    .ctl(ctl), .subKey(subKey)
  );

  assign lastRound = subKeyValid && (roundIdx == RIDX_W'(ROUNDS));
endmodule

// File: rtl/desKeyChk.sv
module desKeyChk
  import desKeyPkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [SUB_W-1:0]  subKey,
  input logic              subKeyValid,
  input logic [RIDX_W-1:0] roundIdx,
  input logic              lastRound
);
  // R2
  start_to_round1_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (subKeyValid && roundIdx == RIDX_W'(1)));

  // R3
  round_step_chk: assert property (@(posedge clk) disable iff (rst)
    (subKeyValid && !start && roundIdx < RIDX_W'(ROUNDS))
      |=> (subKeyValid && roundIdx == $past(roundIdx) + RIDX_W'(1)));

  // R3
  end_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (lastRound && !start) |=> !subKeyValid);

  // R3
  round_range_chk: assert property (@(posedge clk) disable iff (rst)
    subKeyValid |-> (roundIdx >= RIDX_W'(1) && roundIdx <= RIDX_W'(ROUNDS)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!subKeyValid && !start) |=> ($stable(subKey) && $stable(roundIdx)));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!subKeyValid && !lastRound && roundIdx == '0 && subKey == '0));
endmodule

bind des_subkey_gen desKeyChk uChk (
  .clk(clk), .rst(rst), .start(start), .subKey(subKey),
  .subKeyValid(subKeyValid), .roundIdx(roundIdx), .lastRound(lastRound)
);

// File: tb/sim_des_subkey_gen.sv
`timescale 1ns/1ps
module sim_des_subkey_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] keyIn = '0;
  logic        loadKey = 1'b0, start = 1'b0, decrypt = 1'b0;
  logic [47:0] subKey;
  logic        subKeyValid, lastRound;
  logic [4:0]  roundIdx;

  int nRun = 0, nFail = 0;
  bit done = 0;

  always #2 clk = ~clk;  // 250 MHz

  des_subkey_gen u0 (.*);

  localparam logic [63:0] KEY_A  = 64'h133457799BBCDFF1;
  localparam logic [63:0] PAR_M  = 64'h0101010101010101;
  // {decrypt, round, expected subkey}
  localparam logic [53:0] VEC [8] = '{
    {1'b0, 5'd1,  48'h1B02EFFC7072},
    {1'b0, 5'd2,  48'h79AED9DBC9E5},
    {1'b0, 5'd3,  48'h55FC8A42CF99},
    {1'b0, 5'd16, 48'hCB3D8B0E17F5},
    {1'b1, 5'd1,  48'hCB3D8B0E17F5},
    {1'b1, 5'd14, 48'h55FC8A42CF99},
    {1'b1, 5'd15, 48'h79AED9DBC9E5},
    {1'b1, 5'd16, 48'h1B02EFFC7072}};

  logic [47:0] encK [17];
  logic [47:0] decK [17];
  logic [47:0] cap  [17];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic loadK(input logic [63:0] k);
    @(negedge clk); keyIn = k; loadKey = 1'b1;
    @(negedge clk); loadKey = 1'b0;
  endtask

  // start at the current negedge region, capture rounds 1..16
  task automatic runCap(input bit dec);
    start = 1'b1; decrypt = dec;
    @(negedge clk); start = 1'b0;
    for (int r = 1; r <= 16; r++) begin
      cap[r] = subKey;
      if (r < 16) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!subKeyValid && roundIdx == 0 && !lastRound && subKey == 0, "R1 reset", {subKeyValid, roundIdx, subKey}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!subKeyValid && roundIdx == 0 && subKey == 0, "R1 after reset", {subKeyValid, roundIdx, subKey}, 0);

    // forward and reverse captures of the reference key
    loadK(KEY_A);
    runCap(1'b0);
    chk(lastRound && subKeyValid && roundIdx == 16, "R3 last round", {lastRound, roundIdx}, {1'b1, 5'd16});
    for (int r = 1; r <= 16; r++) encK[r] = cap[r];
    @(negedge clk);
    chk(!subKeyValid && !lastRound, "R3 valid drops", subKeyValid, 0);
    @(negedge clk);
    chk(subKey == encK[16] && roundIdx == 16, "R11 idle hold", subKey, encK[16]);
    runCap(1'b1);
    for (int r = 1; r <= 16; r++) decK[r] = cap[r];

    // vector table walk (R4 forward, R5 reverse)
    for (int i = 0; i < 8; i++) begin
      logic [47:0] got;
      got = VEC[i][53] ? decK[VEC[i][52:48]] : encK[VEC[i][52:48]];
      chk(got == VEC[i][47:0], VEC[i][53] ? "R5 vector" : "R4 vector", got, VEC[i][47:0]);
    end
    // R5 mirror of every round
    for (int r = 1; r <= 16; r++)
      chk(decK[r] == encK[17-r], "R5 mirror", decK[r], encK[17-r]);

    // R9 parity bits ignored
    @(negedge clk);
    loadK(KEY_A ^ PAR_M);
    runCap(1'b0);
    chk(cap[1] == encK[1] && cap[16] == encK[16], "R9 parity", cap[1], encK[1]);

    // R6 direction change mid-run has no effect
    @(negedge clk);
    start = 1'b1; decrypt = 1'b0;
    @(negedge clk); start = 1'b0; decrypt = 1'b1;
    repeat (4) @(negedge clk);
    chk(roundIdx == 5 && subKey == encK[5], "R6 mode held", subKey, encK[5]);

    // R7 load during run does not disturb
    @(negedge clk); keyIn = 64'hFFFFFFFFFFFFFFFF; loadKey = 1'b1;
    @(negedge clk); loadKey = 1'b0;
    chk(roundIdx == 7 && subKey == encK[7], "R7 run undisturbed", subKey, encK[7]);

    // R10 restart mid-schedule with new held key (all ones -> all ones)
    start = 1'b1; decrypt = 1'b0;
    @(negedge clk); start = 1'b0;
    chk(roundIdx == 1 && subKeyValid && subKey == 48'hFFFFFFFFFFFF, "R10 restart", {roundIdx, subKey}, {5'd1, 48'hFFFFFFFFFFFF});

    // R7 start together with load uses old held key
    repeat (14) @(negedge clk);
    keyIn = KEY_A; loadKey = 1'b1; start = 1'b1; decrypt = 1'b1;
    @(negedge clk); loadKey = 1'b0; start = 1'b0;
    chk(subKey == 48'hFFFFFFFFFFFF, "R7 same-cycle load", subKey, 48'hFFFFFFFFFFFF);

    // R8 back-to-back: start in round 16 with new direction
    repeat (14) @(negedge clk);
    chk(roundIdx == 15, "R8 setup", roundIdx, 15);
    @(negedge clk);
    chk(lastRound, "R8 at round 16", lastRound, 1);
    start = 1'b1; decrypt = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(subKeyValid && roundIdx == 1 && subKey == encK[16], "R8 back-to-back", {subKeyValid, roundIdx, subKey}, {1'b1, 5'd1, encK[16]});
    @(negedge clk);
    chk(subKey == encK[15] && roundIdx == 2, "R8 reverse round 2", subKey, encK[15]);

    // R2 start sampling
    repeat (20) @(negedge clk);
    start = 1'b1; decrypt = 1'b0;
    @(negedge clk); start = 1'b0;
    chk(subKeyValid && roundIdx == 1 && subKey == encK[1], "R2 start", {roundIdx, subKey}, {5'd1, encK[1]});

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule